// File: doc/BRIEF.md
# Pin-Driven Serial Test Mode Controller

This block turns three dedicated test pins into the chip's operating mode. It runs on the reference oscillator clock. Two of the pins are level selects. The first is an entry-enable pin, `tp_arm`. The second is a reserved select, `tp_rsvd`. The level selects pick one of three states:

- normal operation;
- a reserved debug state;
- test-mode entry.

In test-mode entry, a 5-bit code arrives serially on the data pin `tp_data`. The code picks one test mode:

- outputs pulled high;
- outputs pulled low;
- outputs tri-stated;
- an alternate pull-high test;
- an XOR test mode.

The controller waits while the data pin idles high. The first 0 it samples is the leading bit of a code. The next four samples complete the code. The code is then decoded and the result is latched into a mode register. The one-hot mode enables come from that register.

Dropping both level selects clears all test state at once, with no clock needed. Driving the reserved select high does the same. Because the latched mode lives in flops that are only cleared through the pins, it stays valid if the oscillator stops while entry is held. The controller re-arms as soon as a code completes, so a new code can change the mode at any time without a reset.

Top module: `tmode_ctrl`

## Requirements
- R1: With `tp_arm`=0 and `tp_rsvd`=0, the mode register and all enables clear at once, without waiting for a clock edge, and `debug_mode` follows `tp_data`.
- R2: With `tp_rsvd`=1, every output is 0 whatever the other pins do, and no bit shifted in while it is high changes the mode afterwards.
- R3: In entry (`tp_arm`=1, `tp_rsvd`=0), clock edges that sample `tp_data`=1 while no code is in progress leave the outputs unchanged.
- R4: The first 0 sampled while waiting is bit 4 (the MSB) of a code. The next four rising edges sample bits 3 down to 0, MSB first. The outputs take the decoded value right after the edge that samples bit 0.
- R5: The codes 00001, 00010, 00011, 00100 and 00101 set `mode_code` to 1, 2, 3, 4 and 5 respectively. These stand for alternate pull-high, pull high, pull low, tri-state and XOR.
- R6: The codes 00000 and 00110 through 01111 set `mode_code` to 0 and clear all enables, replacing any earlier mode.
- R7: The edge after the one that completes a code already looks for a new leading 0. Back-to-back codes need no idle bit, and each new code replaces the mode synchronously.
- R8: `en_alt_hi`, `en_pull_hi`, `en_pull_lo`, `en_hiz` and `en_xor` are high exactly when `mode_code` is 1, 2, 3, 4 and 5 respectively. At most one of them is high.
- R9: A latched mode holds while the clock is stopped, for as long as `tp_arm`=1 and `tp_rsvd`=0, even if `tp_data` toggles.
- R10: While a new code is being shifted in, the outputs keep the previous mode until its last bit is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Reference oscillator clock; `tp_data` is sampled on its rising edge |
| tp_data | input | 1 | Serial code input; in the cleared state it selects debug |
| tp_arm | input | 1 | Entry enable; low (with `tp_rsvd` low) clears all test state |
| tp_rsvd | input | 1 | Reserved select; high clears state and silences every output |
| mode_code | output | 3 | Latched test mode, 0 = none, 1..5 as in R5 |
| en_alt_hi | output | 1 | Alternate pull-high test enable |
| en_pull_hi | output | 1 | Pull outputs high enable |
| en_pull_lo | output | 1 | Pull outputs low enable |
| en_hiz | output | 1 | Tri-state outputs enable |
| en_xor | output | 1 | XOR test mode enable |
| debug_mode | output | 1 | Reserved debug state flag |

## Verification
A code's result is due right after the rising edge that samples its fifth bit. There are two registers on that path, the capture counter and the mode flop, and the final bit is decoded combinationally into the mode flop on that same edge. The bench drives each bit on a falling edge and checks the outputs on the falling edge after the fifth rising edge. It also checks one falling edge earlier to confirm that the old mode still holds. The pin-driven clear and the debug flag are combinational with respect to the pins. They are checked a fraction of a cycle after the pin change, while the clock is low, so no edge can account for the result.

// File: rtl/tmode_pkg.sv
`timescale 1ns/1ps
package tmode_pkg;

   // default geometry of the serial mode code
   localparam int unsigned TM_CODE_W  = 5;
   localparam int unsigned TM_MODE_W  = 3;
   localparam int unsigned TM_N_MODES = 5;

   // capture sequencer states
   typedef enum logic {
      CAP_ARMED = 1'b0,   // waiting for a leading zero
      CAP_BODY  = 1'b1    // collecting the remaining code bits
   } cap_state_e;

   // mode values; enable index k is active for mode k+1
   typedef enum logic [TM_MODE_W-1:0] {
      MODE_NONE    = 3'd0,
      MODE_ALT_HI  = 3'd1,
      MODE_PULL_HI = 3'd2,
      MODE_PULL_LO = 3'd3,
      MODE_HIZ     = 3'd4,
      MODE_XOR     = 3'd5
   } mode_e;

endpackage

// File: rtl/tmode_shift.sv
`timescale 1ns/1ps
// Serial capture: arms on the first sampled zero, collects the rest of the
// code MSB first, and flags the edge on which the final bit is present.
module tmode_shift #(
   parameter int unsigned CODE_W = tmode_pkg::TM_CODE_W
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              din,
   output logic              code_vld,
   output logic [CODE_W-1:0] code
);
   import tmode_pkg::*;

   localparam int unsigned BODY_W = CODE_W - 2;
   localparam int unsigned CNT_W  = $clog2(CODE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BODY_W);

   generate
      if (CODE_W < 4) begin : g_bad_code_w
         $error("tmode_shift: CODE_W must be at least 4");
      end
   endgenerate

   cap_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BODY_W-1:0] body_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q   <= CAP_ARMED;
         cnt_q  <= '0;
         body_q <= '0;
      end else begin
         case (st_q)
            CAP_ARMED: begin
               if (!din) begin
                  st_q  <= CAP_BODY;
                  cnt_q <= '0;
               end
            end
            CAP_BODY: begin
               if (cnt_q == LAST) begin
                  st_q <= CAP_ARMED;
               end else begin
                  body_q <= {body_q[BODY_W-2:0], din};
                  cnt_q  <= cnt_q + 1'b1;
               end
            end
            default: st_q <= CAP_ARMED;
         endcase
      end
   end

   // the final bit is taken straight from the pin on the completing edge
   assign code_vld = (st_q == CAP_BODY) && (cnt_q == LAST);
   assign code     = {1'b0, body_q, din};

endmodule

// File: rtl/tmode_latch.sv
`timescale 1ns/1ps
// Decodes a completed code and holds the resulting mode and its enables.
module tmode_latch #(
   parameter int unsigned CODE_W     = tmode_pkg::TM_CODE_W,
   parameter int unsigned MODE_W     = tmode_pkg::TM_MODE_W,
   parameter int unsigned N_MODES    = tmode_pkg::TM_N_MODES,
   parameter bit          REG_ONEHOT = 1'b1
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               code_vld,
   input  logic [CODE_W-1:0]  code,
   output logic [MODE_W-1:0]  mode_q,
   output logic [N_MODES-1:0] en
);
   localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(N_MODES);

   generate
      if (CODE_W <= MODE_W) begin : g_bad_widths
         $error("tmode_latch: CODE_W must exceed MODE_W");
      end
      if (N_MODES >= (1 << MODE_W)) begin : g_bad_modes
         $error("tmode_latch: N_MODES does not fit in MODE_W");
      end
   endgenerate

   logic              valid;
   logic [MODE_W-1:0] nxt_mode;

   always_comb begin
      valid = (code[CODE_W-1:MODE_W] == '0) &&
              (code[MODE_W-1:0] != '0) &&
              (code[MODE_W-1:0] <= TOP_MODE);
      nxt_mode = valid ? code[MODE_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       mode_q <= '0;
      else if (code_vld) mode_q <= nxt_mode;
   end

   generate
      if (REG_ONEHOT) begin : g_en_reg
         // enables get their own flops, loaded alongside the mode
         logic [N_MODES-1:0] en_nxt;
         logic [N_MODES-1:0] en_q;
         for (genvar k = 0; k < N_MODES; k++) begin : g_nxt
            assign en_nxt[k] = (nxt_mode == MODE_W'(k + 1));
         end
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)       en_q <= '0;
            else if (code_vld) en_q <= en_nxt;
         end
         assign en = en_q;
      end else begin : g_en_comb
         // enables decoded from the held mode
         for (genvar k = 0; k < N_MODES; k++) begin : g_dec
            assign en[k] = (mode_q == MODE_W'(k + 1));
         end
      end
   endgenerate

endmodule

// File: rtl/tmode_ctrl.sv
`timescale 1ns/1ps
// Top: pin qualification, pin-derived clear, capture and mode hold.
module tmode_ctrl #(
   parameter int unsigned CODE_W     = tmode_pkg::TM_CODE_W,
   parameter int unsigned MODE_W     = tmode_pkg::TM_MODE_W,
   parameter bit          REG_ONEHOT = 1'b1
) (
   input  logic              clk_osc,
   input  logic              tp_data,
   input  logic              tp_arm,
   input  logic              tp_rsvd,
   output logic [MODE_W-1:0] mode_code,
   output logic              en_alt_hi,
   output logic              en_pull_hi,
   output logic              en_pull_lo,
   output logic              en_hiz,
   output logic              en_xor,
   output logic              debug_mode
);
   import tmode_pkg::*;

   localparam int unsigned N_MODES = TM_N_MODES;

   generate
      if (MODE_W < 3) begin : g_bad_mode_w
         $error("tmode_ctrl: MODE_W must hold five modes");
      end
   endgenerate

   // test logic runs only in entry; any other pin state holds it cleared
   logic entry_n;
   logic arst_n;
   assign entry_n = ~tp_arm | tp_rsvd;
   assign arst_n  = ~entry_n;

   logic              code_vld;
   logic [CODE_W-1:0] code;
   logic [N_MODES-1:0] en;

   tmode_shift #(
      .CODE_W (CODE_W)
   ) u_shift (
      .clk      (clk_osc),
      .arst_n   (arst_n),
      .din      (tp_data),
      .code_vld (code_vld),
      .code     (code)
   );

   tmode_latch #(
      .CODE_W     (CODE_W),
      .MODE_W     (MODE_W),
      .N_MODES    (N_MODES),
      .REG_ONEHOT (REG_ONEHOT)
   ) u_latch (
      .clk      (clk_osc),
      .arst_n   (arst_n),
      .code_vld (code_vld),
      .code     (code),
      .mode_q   (mode_code),
      .en       (en)
   );

   assign en_alt_hi  = en[int'(MODE_ALT_HI)  - 1];
   assign en_pull_hi = en[int'(MODE_PULL_HI) - 1];
   assign en_pull_lo = en[int'(MODE_PULL_LO) - 1];
   assign en_hiz     = en[int'(MODE_HIZ)     - 1];
   assign en_xor     = en[int'(MODE_XOR)     - 1];

   // debug state: both selects low, data pin high
   assign debug_mode = ~tp_rsvd & ~tp_arm & tp_data;

endmodule

// File: rtl/tmode_ctrl_chk.sv
`timescale 1ns/1ps
module tmode_ctrl_chk #(
   parameter int unsigned MODE_W = 3
) (
   input logic              clk_osc,
   input logic              tp_data,
   input logic              tp_arm,
   input logic              tp_rsvd,
   input logic [MODE_W-1:0] mode_code,
   input logic              en_alt_hi,
   input logic              en_pull_hi,
   input logic              en_pull_lo,
   input logic              en_hiz,
   input logic              en_xor,
   input logic              debug_mode
);
   logic [4:0] en_vec;
   logic       in_entry;
   assign en_vec   = {en_xor, en_hiz, en_pull_lo, en_pull_hi, en_alt_hi};
   assign in_entry = tp_arm & ~tp_rsvd;

   // R8
   onehot_en_chk: assert property (@(posedge clk_osc) disable iff (!in_entry)
      $onehot0(en_vec));

   // R8
   mode_en_pair_chk: assert property (@(posedge clk_osc) disable iff (!in_entry)
      (mode_code != '0) |-> ($countones(en_vec) == 1));

   // R5
   mode_range_chk: assert property (@(posedge clk_osc) disable iff (!in_entry)
      mode_code <= MODE_W'(5));

   // R1
   debug_quiet_chk: assert property (@(posedge clk_osc)
      debug_mode |-> (mode_code == '0 && en_vec == '0));

   // R2
   rsvd_quiet_chk: assert property (@(posedge clk_osc)
      tp_rsvd |-> (mode_code == '0 && en_vec == '0 && !debug_mode));

   // R1
   debug_pin_chk: assert property (@(posedge clk_osc)
      (!tp_arm && !tp_rsvd) |-> (debug_mode == tp_data));

endmodule

bind tmode_ctrl tmode_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
   .clk_osc    (clk_osc),
   .tp_data    (tp_data),
   .tp_arm     (tp_arm),
   .tp_rsvd    (tp_rsvd),
   .mode_code  (mode_code),
   .en_alt_hi  (en_alt_hi),
   .en_pull_hi (en_pull_hi),
   .en_pull_lo (en_pull_lo),
   .en_hiz     (en_hiz),
   .en_xor     (en_xor),
   .debug_mode (debug_mode)
);

// File: tb/sim_tmode_ctrl.sv
`timescale 1ns/1ps
module sim_tmode_ctrl;
   logic       clk = 1'b0;
   logic       run = 1'b1;
   logic       tp_data = 1'b0;
   logic       tp_arm = 1'b0;
   logic       tp_rsvd = 1'b0;
   logic [2:0] mode_code;
   logic       en_alt_hi, en_pull_hi, en_pull_lo, en_hiz, en_xor, debug_mode;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   tmode_ctrl u0 (
      .clk_osc    (clk),
      .tp_data    (tp_data),
      .tp_arm     (tp_arm),
      .tp_rsvd    (tp_rsvd),
      .mode_code  (mode_code),
      .en_alt_hi  (en_alt_hi),
      .en_pull_hi (en_pull_hi),
      .en_pull_lo (en_pull_lo),
      .en_hiz     (en_hiz),
      .en_xor     (en_xor),
      .debug_mode (debug_mode)
   );

   // 125 MHz, gateable so the clock can be stopped low
   initial forever begin
      #4;
      if (run) clk = ~clk;
   end

   function automatic logic [8:0] outs();
      return {debug_mode, en_xor, en_hiz, en_pull_lo, en_pull_hi, en_alt_hi, mode_code};
   endfunction

   function automatic logic [8:0] expect_of(input logic [2:0] m, input logic dbg);
      return {dbg, m == 3'd5, m == 3'd4, m == 3'd3, m == 3'd2, m == 3'd1, m};
   endfunction

   function automatic logic [2:0] mode_of(input logic [4:0] c);
      return (c >= 5'd1 && c <= 5'd5) ? c[2:0] : 3'd0;
   endfunction

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   // must be called on a falling edge; returns on the falling edge after bit 0
   task automatic send_code(input logic [4:0] c, input int idle, input logic [2:0] prev);
      for (int i = 0; i < idle; i++) begin
         tp_data = 1'b1;
         @(negedge clk);
      end
      if (idle > 0) check("R3 idle ones", outs(), expect_of(prev, 1'b0));
      for (int i = 4; i >= 0; i--) begin
         if (i == 0) check("R10 old mode kept", outs(), expect_of(prev, 1'b0));
         tp_data = c[i];
         @(negedge clk);
      end
   endtask

   logic [2:0] cur;

   initial begin
      // R1: cleared state, no clock edge involved
      #3;
      check("R1 clear normal", outs(), expect_of(3'd0, 1'b0));
      tp_data = 1'b1; #1;
      check("R1 debug flag", outs(), expect_of(3'd0, 1'b1));

      @(negedge clk);
      tp_arm = 1'b1; tp_data = 1'b1;
      @(negedge clk);
      cur = 3'd0;

      // R4 R5 R6 R7 R8: sweep every code with varying idle gaps
      for (int r = 0; r < 2; r++) begin
         for (int c = 0; c < 16; c++) begin
            logic [2:0] e;
            e = mode_of(5'(c));
            send_code(5'(c), (c + r) % 3, cur);
            if (e != 3'd0)
               check("R5 R4 decode", {6'd0, mode_code}, {6'd0, e});
            else
               check("R6 reserved code", {6'd0, mode_code}, 9'd0);
            check("R8 enables", outs(), expect_of(e, 1'b0));
            cur = e;
         end
      end

      // R7: back-to-back valid codes, each replacing the last
      for (int c = 5; c >= 1; c--) begin
         send_code(5'(c), 0, cur);
         check("R7 back-to-back", outs(), expect_of(3'(c), 1'b0));
         cur = 3'(c);
      end

      // R9: stop the clock with XOR latched, wiggle data
      send_code(5'b00101, 1, cur);
      cur = 3'd5;
      run = 1'b0;
      for (int i = 0; i < 6; i++) begin
         #50 tp_data = ~tp_data;
      end
      #50;
      check("R9 held without clock", outs(), expect_of(3'd5, 1'b0));
      tp_data = 1'b1;
      run = 1'b1;
      @(negedge clk);
      check("R9 held after restart", outs(), expect_of(3'd5, 1'b0));

      // R1: async clear mid-cycle while the clock is low
      #2 tp_arm = 1'b0; tp_data = 1'b0; #1;
      check("R1 async clear", outs(), expect_of(3'd0, 1'b0));
      tp_data = 1'b1; #1;
      check("R1 debug high", outs(), expect_of(3'd0, 1'b1));
      @(negedge clk);
      tp_arm = 1'b1; tp_data = 1'b1;
      @(negedge clk);
      check("R1 entry after clear", outs(), expect_of(3'd0, 1'b0));

      // R2: reserved select silences everything
      send_code(5'b00010, 1, 3'd0);
      check("R2 setup", outs(), expect_of(3'd2, 1'b0));
      #1 tp_rsvd = 1'b1; #1;
      check("R2 rsvd clears", outs(), expect_of(3'd0, 1'b0));
      @(negedge clk);
      send_code(5'b00011, 1, 3'd0);
      check("R2 code ignored", outs(), expect_of(3'd0, 1'b0));
      tp_arm = 1'b0; tp_data = 1'b1; #1;
      check("R2 no debug", outs(), expect_of(3'd0, 1'b0));
      @(negedge clk);
      tp_arm = 1'b1; tp_rsvd = 1'b0;
      @(negedge clk);
      check("R2 no residue", outs(), expect_of(3'd0, 1'b0));
      send_code(5'b00100, 2, 3'd0);
      check("R2 entry resumes", outs(), expect_of(3'd4, 1'b0));

      summary();
   end

   initial begin
      #(8 * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
   end

endmodule